// File: doc/BRIEF.md
# Two-Stage Delay-Lock Search Controller

This block sequences the digital side of a delay-based temperature sensor. Two delay lines stand outside the block. One is a sensor line whose delay varies with temperature and process. The other is a reference line whose per-tap delay is held constant by a locked loop. Each line has a tap selector and an eight-position phase interpolator. A one-bit bang-bang detector compares the two selected edges. The controller drives both tap indices and both interpolator enable words. It runs a coarse tap sweep followed by a fine interpolator sweep, and it stops on the first step at which the swept edge falls behind the frozen edge.

The block has two run modes. A calibration run is made once at a known temperature. It holds the reference line at a fixed setting, searches the sensor line, and stores the sensor setting it finds. A measurement run keeps that stored sensor setting, searches the reference line, and reports the position it finds as a temperature code. Because the stored setting depends on process, dividing it out in this way leaves a code that depends mainly on temperature. A preload port lets a production-programmed setting replace a calibration run.

Top module: `dlock_search_ctrl`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o`, `oor_o`, `code_o` and `temp_o` are 0. The stored setting is 0, so `sens_tap_o`=0 and `sens_ph_en_o`=16'hFF00. The reference outputs show `ref_tap_o`=CAL_REF_TAP (default 18) and the enable word for CAL_REF_PH (default 0).
- R2: For interpolator index k (0..7), the low byte of an enable word has ones in bits [k-1:0] and zeros above them; these are the drivers on the later phase. The high byte is the bitwise complement of the low byte, so exactly 8 of the 16 bits are set, and k=0 gives 16'hFF00.
- R3: `pd_i`=1 means the swept edge leads the frozen edge. A search first steps the tap index t up from 0 with the interpolator index k at 0. When a sample reads 0 and the previous sample read 1 at tap T, the search moves to tap T-1 and steps k up from 1. It ends with code 8*(T-1)+k at the first k that samples 0. If k reaches 7 and still samples 1, the code is 8*T. The code is therefore the first position 8t+k that lags.
- R4: During a calibration run (`meas_mode_i`=0), the reference outputs stay at CAL_REF_TAP and CAL_REF_PH and the sensor line is swept over taps 0..511.
- R5: During a measurement run (`meas_mode_i`=1), the sensor outputs stay at the stored setting and the reference line is swept over taps 0..31. `code_o` is the found position 8t+k, and `temp_o` is that code saturated to 127.
- R6: After each index change, the controller waits `settle_i`+1 clocks before it samples `pd_i`. A run of n samples therefore asserts `done_o` n*(`settle_i`+1) clocks after the edge that accepts start.
- R7: A coarse sweep that reaches its last tap without a 1-to-0 transition ends the run. `oor_o` is set, `code_o` is all ones, and, in measurement mode only, `temp_o` becomes 127. `oor_o` stays set until the next accepted start.
- R8: The stored sensor setting is written by a calibration run that ends in range, with the value tap*8+k = `code_o`. A calibration run that ends out of range leaves it unchanged.
- R9: A `preload_i` pulse while idle, with no start in the same cycle, loads `preload_val_i` (tap in the upper bits, k in the low 3 bits) into the stored setting. A pulse while busy has no effect.
- R10: Start is accepted only while idle. `busy_o` is 1 from the accepting edge until the edge that raises `done_o`, and `done_o` is a one-clock pulse taken with `busy_o` falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a run (honoured while idle) |
| meas_mode_i | input | 1 | 0 = calibration run, 1 = measurement run |
| settle_i | input | SETTLE_W | Extra settle clocks before each sample |
| pd_i | input | 1 | Bang-bang detector, 1 = swept edge leads |
| preload_i | input | 1 | Load stored setting from preload_val_i |
| preload_val_i | input | SENS_TAP_W+PH_W | Setting to preload {tap, k} |
| sens_tap_o | output | SENS_TAP_W | Sensor-line tap index |
| sens_ph_en_o | output | 2*2^PH_W | Sensor interpolator enable word |
| ref_tap_o | output | REF_TAP_W | Reference-line tap index |
| ref_ph_en_o | output | 2*2^PH_W | Reference interpolator enable word |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-clock end-of-run pulse |
| oor_o | output | 1 | Sticky out-of-range flag |
| code_o | output | max(SENS_TAP_W,REF_TAP_W)+PH_W | Found position 8t+k |
| temp_o | output | TEMP_W | Saturated measurement code |

## Verification
Each run's result appears on the clock edge that raises `done_o`. This is n*(`settle_i`+1) clocks after the accepting edge, where n counts the coarse samples up to and including the lagging tap plus the fine samples. The bench derives n from the arithmetic delay model. It counts edges from the start edge to `done_o` and compares that count exactly. It samples every output on the falling edge that follows.

A stored or preloaded setting reaches the index outputs one clock after the store is written. Checks on the stored setting therefore wait two idle clocks and then read it through `sens_tap_o` and `sens_ph_en_o`. The fixed and frozen lines are watched on every falling edge while `busy_o` is high.

// File: rtl/dlock_pkg.sv
package dlock_pkg;
  typedef enum logic [1:0] {
    SRCH_IDLE   = 2'd0,
    SRCH_COARSE = 2'd1,
    SRCH_FINE   = 2'd2
  } srch_state_t;
endpackage

// File: rtl/dls_settle_timer.sv
// Down-counter that spaces detector samples after each index change.
module dls_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dls_phase_enc.sv
// Interpolator index to balanced enable word: low half = later-phase drivers.
module dls_phase_enc #(
  parameter int PH_W = 3,
  localparam int NPH = 1 << PH_W
) (
  input  logic [PH_W-1:0]  idx_i,
  output logic [2*NPH-1:0] en_o
);
  logic [NPH-1:0] late_en;

  for (genvar i = 0; i < NPH; i++) begin : g_drv
    assign late_en[i] = (int'(idx_i) > i);
  end

  assign en_o = {~late_en, late_en};
endmodule

// File: rtl/dls_cal_store.sv
// Holds the sensor-line setting found by calibration or loaded by preload.
module dls_cal_store #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cal_wr_i,
  input  logic [W-1:0] cal_val_i,
  input  logic         pre_wr_i,
  input  logic [W-1:0] pre_val_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
    end else if (cal_wr_i) begin
      val_q <= cal_val_i;
    end else if (pre_wr_i) begin
      val_q <= pre_val_i;
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/dlock_search_ctrl.sv
module dlock_search_ctrl
  import dlock_pkg::*;
#(
  parameter int SENS_TAP_W  = 9,
  parameter int REF_TAP_W   = 5,
  parameter int PH_W        = 3,
  parameter int SETTLE_W    = 8,
  parameter int TEMP_W      = 7,
  parameter int CAL_REF_TAP = 18,
  parameter int CAL_REF_PH  = 0,
  localparam int NPH    = 1 << PH_W,
  localparam int EN_W   = 2 * NPH,
  localparam int TAP_W  = (SENS_TAP_W > REF_TAP_W) ? SENS_TAP_W : REF_TAP_W,
  localparam int CODE_W = TAP_W + PH_W,
  localparam int SC_W   = SENS_TAP_W + PH_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  meas_mode_i,
  input  logic [SETTLE_W-1:0]   settle_i,
  input  logic                  pd_i,
  input  logic                  preload_i,
  input  logic [SC_W-1:0]       preload_val_i,
  output logic [SENS_TAP_W-1:0] sens_tap_o,
  output logic [EN_W-1:0]       sens_ph_en_o,
  output logic [REF_TAP_W-1:0]  ref_tap_o,
  output logic [EN_W-1:0]       ref_ph_en_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  oor_o,
  output logic [CODE_W-1:0]     code_o,
  output logic [TEMP_W-1:0]     temp_o
);
  localparam int SENS_MAX = (1 << SENS_TAP_W) - 1;
  localparam int REF_MAX  = (1 << REF_TAP_W) - 1;
  localparam int TEMP_MAX = (1 << TEMP_W) - 1;
  localparam logic [PH_W-1:0]      PH_MAX    = PH_W'(NPH - 1);
  localparam logic [REF_TAP_W-1:0] CAL_TAP_C = REF_TAP_W'(CAL_REF_TAP);
  localparam logic [PH_W-1:0]      CAL_PH_C  = PH_W'(CAL_REF_PH);
  localparam logic [EN_W-1:0]      EN_RST    = {{NPH{1'b1}}, {NPH{1'b0}}};

  srch_state_t st_q, st_d;
  logic meas_q, meas_d;
  logic prev_q, prev_d;
  logic busy_q, busy_d;
  logic done_q, done_d;
  logic oor_q, oor_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [TEMP_W-1:0] temp_q, temp_d;
  logic [SENS_TAP_W-1:0] sens_tap_q, sens_tap_d;
  logic [PH_W-1:0]       sens_ph_q, sens_ph_d;
  logic [REF_TAP_W-1:0]  ref_tap_q, ref_tap_d;
  logic [PH_W-1:0]       ref_ph_q, ref_ph_d;
  logic [EN_W-1:0] sens_en_q, sens_en_d, ref_en_q, ref_en_d;

  logic tmr_load, tmr_zero;
  logic cal_wr, pre_wr;
  logic [SC_W-1:0] cal_val;
  logic [SENS_TAP_W-1:0] cal_tap;
  logic [PH_W-1:0] cal_ph;

  logic [TAP_W-1:0] cur_tap, tap_max, step_tap;
  logic [PH_W-1:0]  cur_ph, step_ph;
  logic upd, fin, fin_ok;
  logic [CODE_W-1:0] fin_code;

  dls_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .load_val_i(settle_i),
    .expired_o (tmr_zero)
  );

  dls_cal_store #(.W(SC_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .cal_wr_i (cal_wr),
    .cal_val_i(fin_code[SC_W-1:0]),
    .pre_wr_i (pre_wr),
    .pre_val_i(preload_val_i),
    .val_o    (cal_val)
  );

  dls_phase_enc #(.PH_W(PH_W)) u_sens_enc (.idx_i(sens_ph_d), .en_o(sens_en_d));
  dls_phase_enc #(.PH_W(PH_W)) u_ref_enc  (.idx_i(ref_ph_d),  .en_o(ref_en_d));

  assign cal_tap = cal_val[SC_W-1:PH_W];
  assign cal_ph  = cal_val[PH_W-1:0];
  assign pre_wr  = preload_i && (st_q == SRCH_IDLE) && !start_i;

  // The swept line is the sensor line in calibration, the reference line in measurement.
  assign cur_tap = meas_q ? TAP_W'(ref_tap_q) : TAP_W'(sens_tap_q);
  assign cur_ph  = meas_q ? ref_ph_q : sens_ph_q;
  assign tap_max = meas_q ? TAP_W'(REF_MAX) : TAP_W'(SENS_MAX);

  always_comb begin
    st_d       = st_q;
    meas_d     = meas_q;
    prev_d     = prev_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    oor_d      = oor_q;
    code_d     = code_q;
    temp_d     = temp_q;
    sens_tap_d = sens_tap_q;
    sens_ph_d  = sens_ph_q;
    ref_tap_d  = ref_tap_q;
    ref_ph_d   = ref_ph_q;
    tmr_load   = 1'b0;
    cal_wr     = 1'b0;
    upd        = 1'b0;
    fin        = 1'b0;
    fin_ok     = 1'b0;
    fin_code   = '0;
    step_tap   = cur_tap;
    step_ph    = cur_ph;

    unique case (st_q)
      SRCH_IDLE: begin
        sens_tap_d = cal_tap;
        sens_ph_d  = cal_ph;
        ref_tap_d  = CAL_TAP_C;
        ref_ph_d   = CAL_PH_C;
        if (start_i) begin
          st_d     = SRCH_COARSE;
          meas_d   = meas_mode_i;
          prev_d   = 1'b0;
          busy_d   = 1'b1;
          oor_d    = 1'b0;
          tmr_load = 1'b1;
          if (meas_mode_i) begin
            ref_tap_d = '0;
            ref_ph_d  = '0;
          end else begin
            sens_tap_d = '0;
            sens_ph_d  = '0;
          end
        end
      end
      SRCH_COARSE: begin
        if (tmr_zero) begin
          if (prev_q && !pd_i) begin
            // lag first seen at this tap: interpolate upward from the last leading tap
            st_d     = SRCH_FINE;
            step_tap = cur_tap - TAP_W'(1);
            step_ph  = PH_W'(1);
            prev_d   = 1'b1;
            tmr_load = 1'b1;
            upd      = 1'b1;
          end else if (cur_tap == tap_max) begin
            fin = 1'b1;
          end else begin
            step_tap = cur_tap + TAP_W'(1);
            prev_d   = pd_i;
            tmr_load = 1'b1;
            upd      = 1'b1;
          end
        end
      end
      SRCH_FINE: begin
        if (tmr_zero) begin
          if (!pd_i) begin
            fin      = 1'b1;
            fin_ok   = 1'b1;
            fin_code = {cur_tap, cur_ph};
          end else if (cur_ph == PH_MAX) begin
            fin      = 1'b1;
            fin_ok   = 1'b1;
            fin_code = {cur_tap + TAP_W'(1), {PH_W{1'b0}}};
          end else begin
            step_ph  = cur_ph + PH_W'(1);
            tmr_load = 1'b1;
            upd      = 1'b1;
          end
        end
      end
      default: st_d = SRCH_IDLE;
    endcase

    if (upd) begin
      if (meas_q) begin
        ref_tap_d = REF_TAP_W'(step_tap);
        ref_ph_d  = step_ph;
      end else begin
        sens_tap_d = SENS_TAP_W'(step_tap);
        sens_ph_d  = step_ph;
      end
    end

    if (fin) begin
      st_d   = SRCH_IDLE;
      busy_d = 1'b0;
      done_d = 1'b1;
      oor_d  = !fin_ok;
      code_d = fin_ok ? fin_code : '1;
      if (meas_q) begin
        if (!fin_ok || (fin_code > CODE_W'(TEMP_MAX))) begin
          temp_d = TEMP_W'(TEMP_MAX);
        end else begin
          temp_d = fin_code[TEMP_W-1:0];
        end
      end else begin
        cal_wr = fin_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= SRCH_IDLE;
      meas_q     <= 1'b0;
      prev_q     <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      oor_q      <= 1'b0;
      code_q     <= '0;
      temp_q     <= '0;
      sens_tap_q <= '0;
      sens_ph_q  <= '0;
      ref_tap_q  <= CAL_TAP_C;
      ref_ph_q   <= CAL_PH_C;
      sens_en_q  <= EN_RST;
      ref_en_q   <= EN_RST;
    end else begin
      st_q       <= st_d;
      meas_q     <= meas_d;
      prev_q     <= prev_d;
      busy_q     <= busy_d;
      done_q     <= done_d;
      oor_q      <= oor_d;
      code_q     <= code_d;
      temp_q     <= temp_d;
      sens_tap_q <= sens_tap_d;
      sens_ph_q  <= sens_ph_d;
      ref_tap_q  <= ref_tap_d;
      ref_ph_q   <= ref_ph_d;
      sens_en_q  <= sens_en_d;
      ref_en_q   <= ref_en_d;
    end
  end

  assign sens_tap_o   = sens_tap_q;
  assign sens_ph_en_o = sens_en_q;
  assign ref_tap_o    = ref_tap_q;
  assign ref_ph_en_o  = ref_en_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign oor_o        = oor_q;
  assign code_o       = code_q;
  assign temp_o       = temp_q;
endmodule

// File: rtl/dlock_search_chk.sv
module dlock_search_chk #(
  parameter int SENS_TAP_W  = 9,
  parameter int REF_TAP_W   = 5,
  parameter int PH_W        = 3,
  parameter int TEMP_W      = 7,
  parameter int CAL_REF_TAP = 18,
  localparam int NPH    = 1 << PH_W,
  localparam int TAP_W  = (SENS_TAP_W > REF_TAP_W) ? SENS_TAP_W : REF_TAP_W,
  localparam int CODE_W = TAP_W + PH_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  done,
  input logic                  oor,
  input logic                  run_meas,
  input logic [SENS_TAP_W-1:0] sens_tap,
  input logic [2*NPH-1:0]      sens_en,
  input logic [REF_TAP_W-1:0]  ref_tap,
  input logic [2*NPH-1:0]      ref_en,
  input logic [CODE_W-1:0]     code,
  input logic [TEMP_W-1:0]     temp
);
  // R2: balanced, thermometer-coded enable words
  p_en_balanced_r2: assert property (@(posedge clk) disable iff (rst)
    (sens_en[2*NPH-1:NPH] == ~sens_en[NPH-1:0]) &&
    (ref_en[2*NPH-1:NPH] == ~ref_en[NPH-1:0]) &&
    ((sens_en[NPH-1:0] & (sens_en[NPH-1:0] + NPH'(1))) == '0) &&
    ((ref_en[NPH-1:0] & (ref_en[NPH-1:0] + NPH'(1))) == '0));

  // R4: reference line fixed while calibrating
  p_ref_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !run_meas) |-> (ref_tap == REF_TAP_W'(CAL_REF_TAP)));

  // R5: sensor line frozen while measuring
  p_sens_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && run_meas && $past(busy)) |-> ($stable(sens_tap) && $stable(sens_en)));

  // R5: reported temperature never exceeds the code
  p_temp_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (done && run_meas && !oor) |-> (CODE_W'(temp) <= code));

  // R7: out-of-range code saturates
  p_oor_code_r7: assert property (@(posedge clk) disable iff (rst)
    (done && oor) |-> (&code));

  // R7: flag holds while idle
  p_oor_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $past(oor)) |-> oor);

  // R10: done is a single pulse with busy low
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind dlock_search_ctrl dlock_search_chk #(
  .SENS_TAP_W (SENS_TAP_W),
  .REF_TAP_W  (REF_TAP_W),
  .PH_W       (PH_W),
  .TEMP_W     (TEMP_W),
  .CAL_REF_TAP(CAL_REF_TAP)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy_o),
  .done    (done_o),
  .oor     (oor_o),
  .run_meas(meas_q),
  .sens_tap(sens_tap_o),
  .sens_en (sens_ph_en_o),
  .ref_tap (ref_tap_o),
  .ref_en  (ref_ph_en_o),
  .code    (code_o),
  .temp    (temp_o)
);

// File: tb/dlock_search_ctrl_tb_top.sv
module dlock_search_ctrl_tb_top;
  localparam int CAL_TAP = 18;
  localparam int SC_W    = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic meas_mode_i = 1'b0;
  logic [7:0] settle_i = '0;
  logic pd_i;
  logic preload_i = 1'b0;
  logic [SC_W-1:0] preload_val_i = '0;
  logic [8:0]  sens_tap_o;
  logic [15:0] sens_ph_en_o;
  logic [4:0]  ref_tap_o;
  logic [15:0] ref_ph_en_o;
  logic busy_o, done_o, oor_o;
  logic [11:0] code_o;
  logic [6:0]  temp_o;

  int total = 0;
  int fails = 0;
  int su = 20;
  int ru = 20;
  bit cal_mode = 1'b1;
  int exp_store = 0;
  int r4_bad = 0;
  int r5_bad = 0;
  int ks, kr, ds, dr;
  int r_code, r_oor, r_temp, lat;

  always #10 clk = ~clk;

  dlock_search_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .meas_mode_i(meas_mode_i),
    .settle_i(settle_i), .pd_i(pd_i), .preload_i(preload_i),
    .preload_val_i(preload_val_i), .sens_tap_o(sens_tap_o),
    .sens_ph_en_o(sens_ph_en_o), .ref_tap_o(ref_tap_o),
    .ref_ph_en_o(ref_ph_en_o), .busy_o(busy_o), .done_o(done_o),
    .oor_o(oor_o), .code_o(code_o), .temp_o(temp_o)
  );

  // Delay-line and detector model: positions in eighths of a tap.
  always_comb begin
    ks = $countones(sens_ph_en_o[7:0]);
    kr = $countones(ref_ph_en_o[7:0]);
    ds = (8 * int'(sens_tap_o) + ks) * su;
    dr = (8 * int'(ref_tap_o) + kr) * ru;
    pd_i = cal_mode ? (ds < dr) : (dr < ds);
  end

  always @(negedge clk) begin
    if (busy_o) begin
      if (cal_mode && (int'(ref_tap_o) != CAL_TAP || ref_ph_en_o != 16'hFF00)) r4_bad++;
      if (!cal_mode && int'(sens_tap_o) != (exp_store >> 3)) r5_bad++;
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int en_word(input int k);
    int lo;
    lo = (1 << k) - 1;
    return (((~lo) & 8'hFF) << 8) | lo;
  endfunction

  function automatic int n_samples(input int p);
    int t, f;
    t = (p + 7) / 8;
    f = ((p % 8) != 0) ? (p % 8) : 7;
    return t + 1 + f;
  endfunction

  task automatic run_conv(input bit meas, input int settle);
    cal_mode = !meas;
    @(negedge clk);
    start_i = 1'b1; meas_mode_i = meas; settle_i = 8'(settle);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    check(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    while (!done_o && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    check(busy_o == 1'b0, "R10 busy low at done", busy_o, 0);
    r_code = int'(code_o); r_oor = int'(oor_o); r_temp = int'(temp_o);
    @(negedge clk);
    check(done_o == 1'b0, "R10 done single pulse", done_o, 0);
  endtask

  task automatic preload(input int v);
    @(negedge clk);
    preload_i = 1'b1; preload_val_i = SC_W'(v);
    @(negedge clk);
    preload_i = 1'b0;
    exp_store = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic cal_case(input int s_u, input int r_u, input int settle);
    int p;
    su = s_u; ru = r_u;
    p = (CAL_TAP * 8 * r_u + s_u - 1) / s_u;
    run_conv(1'b0, settle);
    if (p > 8 * 511) begin
      check(r_oor == 1, "R7 cal out of range flag", r_oor, 1);
      check(r_code == 4095, "R7 cal saturated code", r_code, 4095);
      check(lat == 512 * (settle + 1), "R6 cal oor latency", lat, 512 * (settle + 1));
    end else begin
      check(r_oor == 0, "R3 cal in range", r_oor, 0);
      check(r_code == p, "R3 cal code", r_code, p);
      check(lat == n_samples(p) * (settle + 1), "R6 cal latency", lat, n_samples(p) * (settle + 1));
      exp_store = p;
    end
    repeat (2) @(negedge clk);
    check(int'(sens_tap_o) == (exp_store >> 3), "R8 stored tap", sens_tap_o, exp_store >> 3);
    check($countones(sens_ph_en_o[7:0]) == (exp_store & 7), "R8 stored phase",
          $countones(sens_ph_en_o[7:0]), exp_store & 7);
  endtask

  task automatic meas_case(input int s_u, input int settle);
    int dsf, m, et;
    su = s_u;
    dsf = exp_store * s_u;
    m = (dsf + ru - 1) / ru;
    run_conv(1'b1, settle);
    if (dsf == 0 || m > 8 * 31) begin
      check(r_oor == 1, "R7 meas out of range flag", r_oor, 1);
      check(r_code == 4095, "R7 meas saturated code", r_code, 4095);
      check(r_temp == 127, "R7 meas saturated temp", r_temp, 127);
      check(lat == 32 * (settle + 1), "R6 meas oor latency", lat, 32 * (settle + 1));
      repeat (3) @(negedge clk);
      check(oor_o == 1'b1, "R7 flag sticky while idle", oor_o, 1);
    end else begin
      et = (m > 127) ? 127 : m;
      check(r_oor == 0, "R5 meas in range", r_oor, 0);
      check(r_code == m, "R5 meas code", r_code, m);
      check(r_temp == et, "R5 meas temp", r_temp, et);
      check(lat == n_samples(m) * (settle + 1), "R6 meas latency", lat, n_samples(m) * (settle + 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy_o == 0 && done_o == 0 && oor_o == 0, "R1 reset flags", {busy_o, done_o, oor_o}, 0);
    check(code_o == 0 && temp_o == 0, "R1 reset code", code_o, 0);
    check(sens_tap_o == 0 && sens_ph_en_o == 16'hFF00, "R1 reset sensor", sens_ph_en_o, 16'hFF00);
    check(int'(ref_tap_o) == CAL_TAP && ref_ph_en_o == 16'hFF00, "R1 reset reference", ref_tap_o, CAL_TAP);

    // R2 and R9: every interpolator index through the preload path
    for (int k = 0; k < 8; k++) begin
      preload(((5 + k) << 3) | k);
      check(int'(sens_ph_en_o) == en_word(k), "R2 enable word", sens_ph_en_o, en_word(k));
      check(int'(sens_tap_o) == 5 + k, "R9 preload tap", sens_tap_o, 5 + k);
    end

    // R3/R4/R6/R8: calibration sweep over sensor delay per tap
    for (int s = 1; s <= 40; s++) cal_case(s, 20, s % 3);
    cal_case(18, 511, 0);   // lag lands on the last tap, phase 0
    cal_case(18, 512, 0);   // beyond the line: store must keep 4088

    // R5/R6/R7: measurement sweep after calibration at nominal conditions
    cal_case(20, 20, 1);
    for (int s = 14; s <= 36; s++) meas_case(s, 1);
    meas_case(20, 2);       // also clears the sticky flag
    check(oor_o == 1'b0, "R7 flag cleared by new start", oor_o, 0);

    // R9/R10: preload and start during a run are ignored
    cal_mode = 1'b0; su = 20;
    @(negedge clk);
    start_i = 1'b1; meas_mode_i = 1'b1; settle_i = 8'd3;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    preload_i = 1'b1; preload_val_i = SC_W'(300); start_i = 1'b1; meas_mode_i = 1'b0;
    @(negedge clk);
    preload_i = 1'b0; start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    check(int'(code_o) == 144, "R10 start ignored while busy", code_o, 144);
    check(int'(temp_o) == 127, "R5 temp saturates above 127", temp_o, 127);
    repeat (3) @(negedge clk);
    check(int'(sens_tap_o) == 18, "R9 preload ignored while busy", sens_tap_o, 18);

    // R7 under-range: stored setting of zero never leads
    preload(0);
    meas_case(20, 0);

    check(r4_bad == 0, "R4 reference held during calibration", r4_bad, 0);
    check(r5_bad == 0, "R5 sensor held during measurement", r5_bad, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule